// File: doc/BRIEF.md
# Single-Accumulator Instruction Processor

This block is a small one-address processor. It fetches 16-bit instruction words from a word-addressed synchronous memory and executes each against one accumulator register. The top four bits of a word select the operation. The low twelve bits name one memory location, which is the operand or the destination. Every arithmetic operation takes the accumulator as its first operand and leaves its result there. A store copies the accumulator out to memory.

The program counter starts at a start address fixed by a parameter. Nothing runs until `start` is pulsed. Instructions then run in address order until a halt code is decoded. The processor then raises `halted` and stays idle until reset.

Memory reads have one cycle of latency. The control sequencer therefore spends one wait state after each instruction fetch and one after each operand read. The accumulator and program counter are brought out on ports for observation.

Top module: `accum_core`

## Requirements
- R1: After reset `acc_out` is 0, `pc_out` equals the START_ADDR parameter, and `halted`, `div_err` and `mem_we` are 0. The program counter does not move until `start` is pulsed high.
- R2: An instruction word is decoded as bits [15:12] = operation code and bits [11:0] = memory address. Instructions are fetched from `pc_out`, and the program counter advances by exactly one after each fetch.
- R3: Code 1 (load) copies the addressed memory word into the accumulator.
- R4: Code 2 (store) writes the accumulator to the addressed location in a single cycle with `mem_we` high, and leaves the accumulator unchanged.
- R5: Code 3 (add) and code 4 (subtract) compute acc + mem and acc - mem, modulo 2^16.
- R6: Code 5 (multiply) keeps the low 16 bits of the two's complement product.
- R7: Code 6 (divide) gives the signed quotient acc / mem, truncated toward zero. The case 0x8000 / 0xFFFF gives 0x8000.
- R8: A divide by zero leaves the accumulator unchanged and sets `div_err`. `div_err` stays set until reset, and execution continues with the next instruction.
- R9: Code 0, and every code from 7 to 15, halts the processor. `halted` goes high, the program counter holds at the address after the halting word, and no further memory writes occur.
- R10: The program load 0x201, add 0x202, add 0x203, store 0x204, halt, with 2, 3 and 4 in memory, leaves 9 at location 0x204.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse to begin execution from the start address |
| mem_addr | output | 12 | Memory word address |
| mem_wdata | output | 16 | Memory write data (the accumulator) |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 16 | Memory read data, valid one cycle after the address |
| halted | output | 1 | Processor has stopped on a halt code |
| div_err | output | 1 | Sticky flag: a divide by zero has occurred |
| acc_out | output | 16 | Accumulator value |
| pc_out | output | 12 | Program counter value |

## Verification
The hardest situations to reach from the ports are the arithmetic corners: the divide overflow 0x8000 / 0xFFFF, and a divide by zero followed by further instructions. Both need a carefully composed program in the bench's memory. The stimulus therefore consists of short hand-assembled programs, each placed at the start address. Each program stores intermediate accumulator values to scratch locations, so every step can be checked afterwards in memory. An undefined operation code is placed before a store that must never happen, and the bench counts memory writes to show that the halt really stopped execution.

// File: rtl/accum_pkg.sv
package accum_pkg;

   localparam int OPC_W = 4;

   typedef enum logic [OPC_W-1:0] {
      OP_HALT = 4'd0,
      OP_LOAD = 4'd1,
      OP_STOR = 4'd2,
      OP_ADD  = 4'd3,
      OP_SUB  = 4'd4,
      OP_MUL  = 4'd5,
      OP_DIV  = 4'd6
   } op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_FWAIT,
      ST_DECODE,
      ST_OPWAIT,
      ST_HALT
   } state_e;

   // Operations that read a memory operand and update the accumulator.
   function automatic logic op_reads_mem(input logic [OPC_W-1:0] op);
      return (op == OP_LOAD) || (op == OP_ADD) || (op == OP_SUB) ||
             (op == OP_MUL)  || (op == OP_DIV);
   endfunction

endpackage

// File: rtl/accum_alu.sv
module accum_alu
   import accum_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic [OPC_W-1:0]  op_i,
   input  logic [DATA_W-1:0] acc_i,
   input  logic [DATA_W-1:0] opnd_i,
   output logic [DATA_W-1:0] res_o,
   output logic              div_zero_o
);

   localparam int EXT_W = DATA_W + 1;

   logic signed [EXT_W-1:0] num_s, den_s, quo_s;
   logic [DATA_W-1:0]       sum_r, dif_r, mul_r, div_r;

   assign sum_r = acc_i + opnd_i;
   assign dif_r = acc_i - opnd_i;
   assign mul_r = acc_i * opnd_i;  // low half of the product

   // One extra bit so the most negative value over minus one does not overflow
   assign num_s = $signed({acc_i[DATA_W-1], acc_i});
   assign den_s = $signed({opnd_i[DATA_W-1], opnd_i});

   always_comb begin
      if (opnd_i == '0) quo_s = '0;
      else              quo_s = num_s / den_s;
   end

   assign div_r = DATA_W'(quo_s);

   assign div_zero_o = (op_i == OP_DIV) && (opnd_i == '0);

   always_comb begin
      unique case (op_i)
         OP_LOAD: res_o = opnd_i;
         OP_ADD:  res_o = sum_r;
         OP_SUB:  res_o = dif_r;
         OP_MUL:  res_o = mul_r;
         OP_DIV:  res_o = (opnd_i == '0) ? acc_i : div_r;
         default: res_o = acc_i;
      endcase
   end

endmodule

// File: rtl/accum_seq.sv
module accum_seq
   import accum_pkg::*;
#(
   parameter int          DATA_W     = 16,
   parameter int          ADDR_W     = 12,
   parameter int unsigned START_ADDR = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] mem_rdata,
   output state_e            state_o,
   output logic [OPC_W-1:0]  op_o,
   output logic [ADDR_W-1:0] pc_o,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_we,
   output logic              exec_o
);

   localparam logic [ADDR_W-1:0] PC_RST = ADDR_W'(START_ADDR);

   state_e            state_q, state_d;
   logic [DATA_W-1:0] ir_q;
   logic [ADDR_W-1:0] pc_q;
   logic [OPC_W-1:0]  ir_op;
   logic [ADDR_W-1:0] ir_addr;

   assign ir_op   = ir_q[DATA_W-1 -: OPC_W];
   assign ir_addr = ir_q[ADDR_W-1:0];

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:   if (start) state_d = ST_FETCH;
         ST_FETCH:  state_d = ST_FWAIT;
         ST_FWAIT:  state_d = ST_DECODE;
         ST_DECODE: begin
            if (ir_op == OP_STOR)         state_d = ST_FETCH;
            else if (op_reads_mem(ir_op)) state_d = ST_OPWAIT;
            else                          state_d = ST_HALT;
         end
         ST_OPWAIT: state_d = ST_FETCH;
         default:   state_d = ST_HALT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         ir_q    <= '0;
         pc_q    <= PC_RST;
      end else begin
         state_q <= state_d;
         if (state_q == ST_FWAIT) begin
            ir_q <= mem_rdata;
            pc_q <= pc_q + ADDR_W'(1);
         end
      end
   end

   assign mem_addr = (state_q == ST_DECODE) ? ir_addr : pc_q;
   assign mem_we   = (state_q == ST_DECODE) && (ir_op == OP_STOR);
   assign exec_o   = (state_q == ST_OPWAIT);
   assign state_o  = state_q;
   assign op_o     = ir_op;
   assign pc_o     = pc_q;

   assert_idle_pc_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE) |-> (pc_q == PC_RST));

   assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_FWAIT) |=> (pc_q == $past(pc_q) + ADDR_W'(1)));

   assert_halt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_HALT) |=> ((state_q == ST_HALT) && $stable(pc_q) && !mem_we));

endmodule

// File: rtl/accum_core.sv
module accum_core
   import accum_pkg::*;
#(
   parameter int          DATA_W     = 16,
   parameter int          ADDR_W     = 12,
   parameter int unsigned START_ADDR = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_we,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              halted,
   output logic              div_err,
   output logic [DATA_W-1:0] acc_out,
   output logic [ADDR_W-1:0] pc_out
);

   generate
      if (DATA_W != OPC_W + ADDR_W) begin : g_bad_width
         $error("instruction word must hold opcode plus address");
      end
      if (START_ADDR >= (64'd1 << ADDR_W)) begin : g_bad_start
         $error("start address outside the address space");
      end
   endgenerate

   state_e            state;
   logic [OPC_W-1:0]  op;
   logic              exec;
   logic [DATA_W-1:0] alu_res;
   logic              div_zero;
   logic [DATA_W-1:0] acc_q;
   logic              derr_q;

   accum_seq #(
      .DATA_W    (DATA_W),
      .ADDR_W    (ADDR_W),
      .START_ADDR(START_ADDR)
   ) i_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .mem_rdata(mem_rdata),
      .state_o  (state),
      .op_o     (op),
      .pc_o     (pc_out),
      .mem_addr (mem_addr),
      .mem_we   (mem_we),
      .exec_o   (exec)
   );

   accum_alu #(
      .DATA_W(DATA_W)
   ) i_alu (
      .op_i      (op),
      .acc_i     (acc_q),
      .opnd_i    (mem_rdata),
      .res_o     (alu_res),
      .div_zero_o(div_zero)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         derr_q <= 1'b0;
      end else if (exec) begin
         acc_q <= alu_res;
         if (div_zero) derr_q <= 1'b1;
      end
   end

   assign mem_wdata = acc_q;
   assign acc_out   = acc_q;
   assign div_err   = derr_q;
   assign halted    = (state == ST_HALT);

   assert_store_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> (!mem_we && $stable(acc_q)));

   assert_divzero_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && div_zero) |=> ($stable(acc_q) && derr_q));

   assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      derr_q |=> derr_q);

   assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted);

endmodule

// File: tb/test_accum_core.sv
module test_accum_core;

   localparam int DW = 16;
   localparam int AW = 12;
   localparam logic [AW-1:0] ORG = 12'h101;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic          mem_we;
   logic [DW-1:0] mem_rdata;
   logic          halted, div_err;
   logic [DW-1:0] acc_out;
   logic [AW-1:0] pc_out;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   int wr_count = 0;

   logic [DW-1:0] mem [0:(1<<AW)-1];

   always #2.5 clk = ~clk;

   accum_core #(.DATA_W(DW), .ADDR_W(AW), .START_ADDR(ORG)) i_accum_core (
      .clk(clk), .rst_n(rst_n), .start(start),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
      .mem_rdata(mem_rdata), .halted(halted), .div_err(div_err),
      .acc_out(acc_out), .pc_out(pc_out));

   // synchronous memory with one cycle read latency
   always @(posedge clk) begin
      if (mem_we) begin
         mem[mem_addr] <= mem_wdata;
         wr_count <= wr_count + 1;
      end
      mem_rdata <= mem[mem_addr];
   end

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         errors = errors + 1;
         $display("FAIL watchdog: run did not complete");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   function automatic logic [DW-1:0] ins(input logic [3:0] op, input logic [AW-1:0] a);
      return {op, a};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks = checks + 1;
      if (act !== exp) begin
         errors = errors + 1;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
      repeat (2) @(negedge clk);
   endtask

   task automatic go();
      rst_n = 1'b1;
      @(negedge clk);
      wr_count = 0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_halt(input string req);
      int n = 0;
      while (!halted && n < 2000) begin
         @(negedge clk);
         n++;
      end
      check(req, {31'd0, halted}, 32'd1);
   endtask

   task automatic t_reset();
      do_reset();
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 acc", acc_out, 0);
      check("R1 pc", pc_out, ORG);
      check("R1 halted", halted, 0);
      check("R1 div_err", div_err, 0);
      check("R1 we", mem_we, 0);
      repeat (10) @(negedge clk);
      check("R1 pc waits for start", pc_out, ORG);
   endtask

   task automatic t_sum();
      do_reset();
      mem[12'h101] = ins(1, 12'h201);
      mem[12'h102] = ins(3, 12'h202);
      mem[12'h103] = ins(3, 12'h203);
      mem[12'h104] = ins(2, 12'h204);
      mem[12'h105] = ins(0, 12'h000);
      mem[12'h201] = 16'd2;
      mem[12'h202] = 16'd3;
      mem[12'h203] = 16'd4;
      go();
      wait_halt("R9 halt code 0");
      check("R10 sum stored", mem[12'h204], 9);
      check("R4 acc kept after store", acc_out, 9);
      check("R2 pc after halt word", pc_out, 12'h106);
      check("R4 one write", wr_count, 1);
   endtask

   task automatic t_arith();
      logic [DW-1:0] e_mul;
      do_reset();
      mem[12'h101] = ins(1, 12'h200);
      mem[12'h102] = ins(3, 12'h201);
      mem[12'h103] = ins(2, 12'h300);
      mem[12'h104] = ins(4, 12'h202);
      mem[12'h105] = ins(2, 12'h301);
      mem[12'h106] = ins(5, 12'h203);
      mem[12'h107] = ins(2, 12'h302);
      mem[12'h108] = ins(0, 12'h000);
      mem[12'h200] = 16'h7FFF;
      mem[12'h201] = 16'h0001;
      mem[12'h202] = 16'h0003;
      mem[12'h203] = 16'hFFFD;
      e_mul = 16'h7FFD * 16'hFFFD;
      go();
      wait_halt("R9 arith halt");
      check("R5 add wraps", mem[12'h300], 16'h8000);
      check("R5 sub wraps", mem[12'h301], 16'h7FFD);
      check("R6 mul low half", mem[12'h302], e_mul);
      check("R3 load then ops acc", acc_out, e_mul);
   endtask

   task automatic t_div();
      do_reset();
      mem[12'h101] = ins(1, 12'h200);
      mem[12'h102] = ins(6, 12'h201);
      mem[12'h103] = ins(2, 12'h300);
      mem[12'h104] = ins(1, 12'h202);
      mem[12'h105] = ins(6, 12'h203);
      mem[12'h106] = ins(2, 12'h301);
      mem[12'h107] = ins(1, 12'h204);
      mem[12'h108] = ins(6, 12'h205);
      mem[12'h109] = ins(2, 12'h302);
      mem[12'h10A] = ins(0, 12'h000);
      mem[12'h200] = 16'hFFF9;  // -7
      mem[12'h201] = 16'h0002;
      mem[12'h202] = 16'h0007;
      mem[12'h203] = 16'hFFFE;  // -2
      mem[12'h204] = 16'h8000;
      mem[12'h205] = 16'hFFFF;
      go();
      wait_halt("R9 div halt");
      check("R7 -7/2", mem[12'h300], 16'hFFFD);
      check("R7 7/-2", mem[12'h301], 16'hFFFD);
      check("R7 min/-1", mem[12'h302], 16'h8000);
      check("R8 no error flagged", div_err, 0);
   endtask

   task automatic t_divzero();
      do_reset();
      mem[12'h101] = ins(1, 12'h200);
      mem[12'h102] = ins(6, 12'h201);
      mem[12'h103] = ins(2, 12'h300);
      mem[12'h104] = ins(3, 12'h202);
      mem[12'h105] = ins(2, 12'h301);
      mem[12'h106] = ins(0, 12'h000);
      mem[12'h200] = 16'h1234;
      mem[12'h201] = 16'h0000;
      mem[12'h202] = 16'h0001;
      go();
      wait_halt("R8 runs on after div by zero");
      check("R8 acc unchanged", mem[12'h300], 16'h1234);
      check("R8 continues", mem[12'h301], 16'h1235);
      check("R8 flag set", div_err, 1);
      do_reset();
      rst_n = 1'b1;
      @(negedge clk);
      check("R8 flag cleared by reset", div_err, 0);
   endtask

   task automatic t_badop();
      do_reset();
      mem[12'h101] = ins(1, 12'h200);
      mem[12'h102] = ins(2, 12'h300);
      mem[12'h103] = ins(4'hB, 12'h000);
      mem[12'h104] = ins(2, 12'h301);
      mem[12'h200] = 16'h0055;
      go();
      wait_halt("R9 undefined code halts");
      check("R9 pc holds", pc_out, 12'h104);
      repeat (20) @(negedge clk);
      check("R9 pc still", pc_out, 12'h104);
      check("R9 no later store", mem[12'h301], 0);
      check("R9 write count", wr_count, 1);
      check("R3 load value", acc_out, 16'h0055);
   endtask

   initial begin
      t_reset();
      t_sum();
      t_arith();
      t_div();
      t_divzero();
      t_badop();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule